// File: doc/BRIEF.md
# Card Data Frame Receiver

This block takes the single-bit data line of a memory card and turns one incoming data frame into bytes for a receive FIFO. Software selects the receive direction, chooses block or stream framing and, for block framing, the payload length in bytes, then arms the receiver. The card begins its frame only after an access delay of unknown length, so the armed receiver waits with no time limit for the start bit. Line samples are qualified by a bit strobe that comes from the card clock logic.

Payload bits are assembled most significant bit first. In block framing, a 16-bit CRC follows the payload and is checked against the polynomial x^16+x^12+x^5+1 with a starting value of zero. In stream framing, the frame runs until software issues a stop request. Either way, the frame closes with an end bit. A single end-of-frame pulse then reports completion, and two held status bits report whether the end bit was valid and whether the CRC matched. If the card never responds, software recovers by raising and then dropping a reset control, which returns the receiver to idle.

Top module: `card_rx_frame`

## Requirements
- R1: An arm request is accepted only while `dir_tx` is 0. An arm request made while `dir_tx` is 1 leaves the receiver idle, so later line activity produces no byte and no end-of-frame pulse.
- R2: After it is armed, the receiver waits with no time limit. The first strobed sample equal to 0 is the start bit, and strobed samples equal to 1 before it are ignored.
- R3: Payload bits are shifted in MSB first. On the clock after the strobe that carries the eighth bit of a byte, `byte_valid` is high for one cycle and `byte_data` holds the byte.
- R4: In block mode (`stream_mode`=0), the 16 strobed bits after the last payload byte are a CRC, sent MSB first. `crc_ok` is set to 1 if the remainder over the payload and the CRC is zero (polynomial 0x1021, initial value 0) and is set to 0 otherwise.
- R5: The strobed bit that follows the frame is the end bit. `end_ok` is set to 1 if that bit is 1 and is set to 0 if it is 0.
- R6: `eof` pulses for exactly one cycle, on the clock after the end-bit strobe. `end_ok` and `crc_ok` take their new values at that same clock and hold them until the next accepted arm or a soft reset, either of which clears both bits.
- R7: In stream mode (`stream_mode`=1), a `stop_req` while payload is being received discards any partial byte, and that cycle's strobe is not used as data. The next strobed bit is taken as the end bit, and `crc_ok` stays 0.
- R8: While `soft_rst` is 1, the receiver goes to idle and outputs no byte or `eof`, and `end_ok` and `crc_ok` are cleared. After `soft_rst` returns to 0, a new arm is needed before any frame is received.
- R9: The number of payload bytes in block mode is `blk_len` (at least 1), sampled when the arm is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_tx | input | 1 | Direction select: 0 selects receive |
| stream_mode | input | 1 | 1 selects stream framing, 0 selects block framing |
| blk_len | input | LEN_W | Payload bytes per block |
| arm | input | 1 | Single-cycle request to start waiting for a frame |
| stop_req | input | 1 | Single-cycle request to end a stream frame |
| soft_rst | input | 1 | Software reset of the receive state machine |
| bit_en | input | 1 | Strobe that qualifies a sample of the data line |
| dat_in | input | 1 | Card data line |
| byte_valid | output | 1 | Single-cycle write strobe to the receive FIFO |
| byte_data | output | DATA_W | Received byte |
| eof | output | 1 | End-of-frame pulse, usable as an interrupt request |
| end_ok | output | 1 | Status: a valid end bit was received |
| crc_ok | output | 1 | Status: the CRC16 check passed (block mode only) |

## Verification
The assertions check several rules on every cycle. While the transmit direction is selected, the receiver stays idle. While it waits, it keeps waiting until a 0 is sampled. Every byte strobe follows a line strobe. The end-of-frame pulse lasts a single cycle. A stream frame never reports a CRC pass. A soft reset leaves the receiver idle with its outputs quiet. The bench's scenarios are the only evidence for the values: MSB-first byte contents, the CRC verdict on good and corrupted blocks of different lengths, the end-bit verdict, a partial byte discarded at a stream stop, and the need to re-arm after a soft reset. The bench compares these against a behavioural model on every clock.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_WAIT,
    RX_DATA,
    RX_CRC,
    RX_END
  } rx_state_t;

  localparam int unsigned CRC_BITS = 16;
  localparam logic [CRC_BITS-1:0] CRC_POLY_DEF = 16'h1021;

endpackage

// File: rtl/card_rx_crc16.sv
module card_rx_crc16 #(
  parameter int unsigned      CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ din;
    crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/card_rx_shift.sv
module card_rx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic              done,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    word = {sr_q[DATA_W-2:0], din};
    done = en && (cnt_q == CNT_W'(DATA_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      sr_q  <= word;
      cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/card_rx_frame.sv
module card_rx_frame
  import card_rx_pkg::*;
#(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CB_W  = $clog2(CRC_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_tx,
  input  logic              stream_mode,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              arm,
  input  logic              stop_req,
  input  logic              soft_rst,
  input  logic              bit_en,
  input  logic              dat_in,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              eof,
  output logic              end_ok,
  output logic              crc_ok
);

  rx_state_t             state_q, state_d;
  logic                  mode_q;
  logic [LEN_W-1:0]      len_q, byte_cnt_q;
  logic [CB_W-1:0]       cb_cnt_q;
  logic                  arm_ok, stop_hit, shift_en, crc_en, sect_clr;
  logic                  byte_done, last_byte, end_smp;
  logic [DATA_W-1:0]     word;
  logic [CRC_BITS-1:0]   crc;

  always_comb begin
    arm_ok    = (state_q == RX_IDLE) && arm && !dir_tx && !soft_rst;
    stop_hit  = (state_q == RX_DATA) && mode_q && stop_req;
    shift_en  = (state_q == RX_DATA) && bit_en && !stop_hit;
    crc_en    = shift_en || ((state_q == RX_CRC) && bit_en);
    sect_clr  = (state_q == RX_WAIT) || soft_rst;
    last_byte = !mode_q && byte_done && (byte_cnt_q == len_q - LEN_W'(1));
    end_smp   = (state_q == RX_END) && bit_en && !soft_rst;
  end

  card_rx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .clr(sect_clr), .en(shift_en), .din(dat_in),
    .done(byte_done), .word(word)
  );

  card_rx_crc16 #(.CRC_W(CRC_BITS), .POLY(CRC_POLY_DEF)) i_crc (
    .clk(clk), .rst_n(rst_n), .clr(sect_clr), .en(crc_en), .din(dat_in),
    .crc(crc)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE: if (arm_ok) state_d = RX_WAIT;
      RX_WAIT: if (bit_en && !dat_in) state_d = RX_DATA;
      RX_DATA: begin
        if (stop_hit)       state_d = RX_END;
        else if (last_byte) state_d = RX_CRC;
      end
      RX_CRC:  if (bit_en && (cb_cnt_q == CB_W'(CRC_BITS - 1))) state_d = RX_END;
      RX_END:  if (bit_en) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
    if (soft_rst) state_d = RX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  // frame setup captured at arm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      len_q  <= '0;
    end else if (arm_ok) begin
      mode_q <= stream_mode;
      len_q  <= blk_len;
    end
  end

  // byte and crc-bit counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         byte_cnt_q <= '0;
    else if (sect_clr)  byte_cnt_q <= '0;
    else if (byte_done) byte_cnt_q <= byte_cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cb_cnt_q <= '0;
    else if (state_q == RX_DATA)          cb_cnt_q <= '0;
    else if (state_q == RX_CRC && bit_en) cb_cnt_q <= cb_cnt_q + CB_W'(1);
  end

  // FIFO write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= byte_done && !soft_rst;
      if (byte_done) byte_data <= word;
    end
  end

  // end-of-frame event and held status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof    <= 1'b0;
      end_ok <= 1'b0;
      crc_ok <= 1'b0;
    end else begin
      eof <= end_smp;
      if (soft_rst || arm_ok) begin
        end_ok <= 1'b0;
        crc_ok <= 1'b0;
      end else if (end_smp) begin
        end_ok <= dat_in;
        crc_ok <= !mode_q && (crc == '0);
      end
    end
  end

endmodule

// File: rtl/card_rx_frame_chk.sv
module card_rx_frame_chk
  import card_rx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      soft_rst,
  input logic      dir_tx,
  input logic      bit_en,
  input logic      dat_in,
  input logic      byte_valid,
  input logic      eof,
  input logic      crc_ok,
  input logic      mode,
  input rx_state_t state
);

  AST_DIR_GATES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && dir_tx) |=> (state == RX_IDLE)); // R1

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAIT && !soft_rst && !(bit_en && !dat_in)) |=> (state == RX_WAIT)); // R2

  AST_BYTE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_en)); // R3

  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof); // R6

  AST_EOF_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> ($past(state) == RX_END)); // R5

  AST_STREAM_NO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && mode) |-> !crc_ok); // R7

  AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state == RX_IDLE && !eof && !byte_valid)); // R8

endmodule

bind card_rx_frame card_rx_frame_chk i_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dir_tx(dir_tx),
  .bit_en(bit_en), .dat_in(dat_in), .byte_valid(byte_valid), .eof(eof),
  .crc_ok(crc_ok), .mode(mode_q), .state(state_q)
);

// File: tb/test_card_rx_frame.sv
module test_card_rx_frame;

  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_tx = 1'b0, stream_mode = 1'b0, arm = 1'b0, stop_req = 1'b0;
  logic soft_rst = 1'b0, bit_en = 1'b0, dat_in = 1'b1;
  logic [LEN_W-1:0] blk_len = '0;
  logic byte_valid, eof, end_ok, crc_ok;
  logic [7:0] byte_data;

  always #10 clk = ~clk;

  card_rx_frame #(.LEN_W(LEN_W)) i_card_rx_frame (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .stream_mode(stream_mode),
    .blk_len(blk_len), .arm(arm), .stop_req(stop_req), .soft_rst(soft_rst),
    .bit_en(bit_en), .dat_in(dat_in), .byte_valid(byte_valid),
    .byte_data(byte_data), .eof(eof), .end_ok(end_ok), .crc_ok(crc_ok)
  );

  int vecs = 0, errs = 0;
  string cur_req = "R8";

  // behavioural model: 0 idle, 1 wait, 2 payload, 3 crc, 4 end bit
  int m_phase = 0, m_stream = 0, m_len = 0, m_nbit = 0, m_nbyte = 0, m_ncrc = 0;
  int m_acc = 0, m_crc = 0;
  bit m_end = 0, m_crcok = 0, e_bv = 0, e_eof = 0;
  int e_byte = 0;
  int g_crc = 0;

  function automatic int crc_upd(int c, bit d);
    int fb = ((c >> 15) & 1) ^ d;
    return ((c << 1) & 32'hFFFF) ^ (fb ? 32'h1021 : 0);
  endfunction

  task automatic step(input bit be, input bit d);
    bit_en = be; dat_in = d;
    e_bv = 0; e_eof = 0;
    if (soft_rst) begin
      m_phase = 0; m_end = 0; m_crcok = 0;
    end else begin
      case (m_phase)
        0: if (arm && !dir_tx) begin
             m_phase = 1; m_stream = stream_mode; m_len = blk_len;
             m_end = 0; m_crcok = 0;
           end
        1: if (be && !d) begin
             m_phase = 2; m_nbit = 0; m_nbyte = 0; m_acc = 0; m_crc = 0;
           end
        2: if (m_stream != 0 && stop_req) m_phase = 4;
           else if (be) begin
             m_acc = ((m_acc << 1) | d) & 8'hFF;
             m_crc = crc_upd(m_crc, d);
             m_nbit++;
             if (m_nbit == 8) begin
               e_bv = 1; e_byte = m_acc; m_nbit = 0; m_nbyte++;
               if (m_stream == 0 && m_nbyte == m_len) begin m_phase = 3; m_ncrc = 0; end
             end
           end
        3: if (be) begin
             m_crc = crc_upd(m_crc, d); m_ncrc++;
             if (m_ncrc == 16) m_phase = 4;
           end
        4: if (be) begin
             e_eof = 1; m_end = d; m_crcok = (m_stream == 0) && (m_crc == 0); m_phase = 0;
           end
        default: m_phase = 0;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    vecs++;
    if (byte_valid !== e_bv || (e_bv && byte_data !== 8'(e_byte)) || eof !== e_eof ||
        end_ok !== m_end || crc_ok !== m_crcok) begin
      errs++;
      $display("FAIL %s: got bv=%b byte=%h eof=%b end_ok=%b crc_ok=%b, exp bv=%b byte=%h eof=%b end_ok=%b crc_ok=%b",
               cur_req, byte_valid, byte_data, eof, end_ok, crc_ok,
               e_bv, 8'(e_byte), e_eof, m_end, m_crcok);
    end
  endtask

  task automatic send_bit(input bit b);
    step(1'b1, b);
    step(1'b0, 1'b1);
  endtask

  task automatic do_arm();
    arm = 1'b1; step(1'b0, 1'b1); arm = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i]);
      g_crc = crc_upd(g_crc, b[i]);
    end
  endtask

  task automatic send_crc(input bit corrupt);
    logic [15:0] c = 16'(g_crc);
    if (corrupt) c[3] = ~c[3];
    for (int i = 15; i >= 0; i--) send_bit(c[i]);
  endtask

  initial begin
    #(200000 * 20);
    errs++; vecs++;
    $display("FAIL watchdog: run did not finish, got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R8";                       // reset state
    repeat (3) step(1'b0, 1'b1);

    cur_req = "R1";                       // arm refused while transmitting
    dir_tx = 1'b1; blk_len = 1;
    do_arm();
    send_bit(1'b0);
    send_byte(8'hC3);
    repeat (18) send_bit(1'b1);
    dir_tx = 1'b0;

    cur_req = "R2";                       // long wait, ones ignored
    stream_mode = 1'b0; blk_len = 4;
    do_arm();
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    send_bit(1'b0);
    cur_req = "R3";                       // MSB-first bytes, R9 length 4
    g_crc = 0;
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00);
    cur_req = "R4";                       // good CRC
    send_crc(1'b0);
    cur_req = "R6";                       // eof pulse, held status
    send_bit(1'b1);
    repeat (6) step(1'b0, 1'b1);

    cur_req = "R5";                       // bad end bit and bad CRC, R9 length 1
    blk_len = 1;
    do_arm();
    send_bit(1'b1); send_bit(1'b0);
    g_crc = 0;
    send_byte(8'h81);
    send_crc(1'b1);
    send_bit(1'b0);
    repeat (3) step(1'b0, 1'b1);

    cur_req = "R7";                       // stream frame with partial byte
    stream_mode = 1'b1;
    do_arm();
    send_bit(1'b0);
    send_byte(8'h5A); send_byte(8'h12); send_byte(8'hE7);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    stop_req = 1'b1; step(1'b1, 1'b0); stop_req = 1'b0;
    send_bit(1'b1);
    repeat (3) step(1'b0, 1'b1);

    cur_req = "R8";                       // soft reset mid-frame, then no re-arm
    stream_mode = 1'b0; blk_len = 2;
    do_arm();
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    soft_rst = 1'b1;
    send_bit(1'b0); send_bit(1'b1);
    soft_rst = 1'b0;
    send_bit(1'b0);
    send_byte(8'h77); send_byte(8'h11);
    repeat (20) send_bit(1'b1);

    cur_req = "R9";                       // re-arm after soft reset, length 2
    do_arm();
    send_bit(1'b0);
    g_crc = 0;
    send_byte(8'h0F); send_byte(8'hF0);
    send_crc(1'b0);
    send_bit(1'b1);
    repeat (3) step(1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule